// File: doc/BRIEF.md
# SPI Host Character Transmitter

This block is the transmit half of a serial port acting as an SPI host. Software places one character at a time into a holding register. At the next half-bit tick on which the shifter is free, the block moves that character into a shift register. It then sends the character MSB first on a serial clock it generates itself, and it drives an active-low client select around each character. Two flags report progress. The ready flag means the holding register can take a new character. The empty flag means every accepted character has been sent in full.

All timing comes from a one-cycle `half_tick` input that the surrounding baud logic supplies at twice the bit rate. One bit period therefore equals two ticks. Select falls one bit period before the MSB and rises one bit period after the LSB. It then stays high for at least one more bit period, so at least three bit periods separate the end of one LSB from the start of the next MSB. Two options change this behaviour. With `hold_for_rx` set, a character is not started while the receive side still holds an unread character. A force-select command holds select low across characters until a release command arrives.

Top module: `spi_host_tx`

## Requirements
- R1: While `rst` is high and after it is released with `tx_en` low: `sel_n`=1, `sclk`=0, `mosi`=0, `tx_ready`=0 and `tx_empty`=0.
- R2: A character is 8 bits and is sent MSB first. `sclk` idles low. Each bit occupies two ticks: `sclk` is low for the first tick and high for the second. `mosi` changes only while `sclk` is low, so the receiver samples on the rising edge.
- R3: On the tick that starts a character, `sel_n` falls. The MSB's low half begins two ticks later, which is one bit period.
- R4: After the LSB's high half, `sel_n` stays low for two more ticks and then, unless select is forced, stays high for at least two ticks. The next MSB therefore starts at least six ticks after the previous LSB ends.
- R5: `tx_ready` is `tx_en` AND (holding register empty). It rises in the cycle after the tick that moves the held character into the shift register.
- R6: `tx_empty` is high only when `tx_en` is high, the holding register is empty and no character is being shifted.
- R7: With `tx_en` low, both flags are low and a frame in progress is dropped. Select is then high unless forced, and writes are ignored. Enabling again makes both flags high.
- R8: A `wr_valid` pulse while `tx_ready` is low is ignored: the character is discarded and never appears on `mosi`.
- R9: With `hold_for_rx`=1, a character starts only on a tick where `rx_full`=0. With `hold_for_rx`=0, `rx_full` has no effect.
- R10: A `force_sel_on` pulse drives `sel_n` low from the next cycle, including between characters. `sel_n` can return high only after a `force_sel_off` pulse, and `force_sel_off` wins when both pulses arrive together.
- R11: Outputs `sclk`, `mosi` and the frame part of `sel_n` change only in the cycle after a tick, or after `tx_en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| half_tick | input | 1 | One-cycle pulse, two per bit period |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| hold_for_rx | input | 1 | Wait for the receive holding register to be read |
| rx_full | input | 1 | Receive side holds an unread character |
| force_sel_on | input | 1 | Force select low |
| force_sel_off | input | 1 | Release forced select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| sel_n | output | 1 | Active-low client select |
| tx_ready | output | 1 | Holding register empty |
| tx_empty | output | 1 | All characters sent |

## Verification
Every state change lands on the clock edge that samples its cause. A write, a tick that starts or advances a frame, an enable change, and a force or release pulse are therefore all visible on the outputs one clock later, with no further register on the way. The bench drives inputs on the falling edge and keeps a behavioural model that it advances on the rising edge. It compares all five outputs one nanosecond after every rising edge. Bytes rebuilt from `mosi` at each `sclk` rise are compared with the characters the model completed. Point checks are placed where a result must have settled, such as ninety cycles into a hold-off.

// File: rtl/spi_host_tx_pkg.sv
package spi_host_tx_pkg;
  // Ticks per bit period.
  localparam int TICKS_PER_BIT = 2;
  // Bit periods of select setup before the MSB, hold after the LSB, and release.
  localparam int LEAD_BITS  = 1;
  localparam int TRAIL_BITS = 1;
  localparam int GAP_BITS   = 1;

  function automatic int frame_ticks(input int dw);
    return TICKS_PER_BIT * (dw + LEAD_BITS + TRAIL_BITS + GAP_BITS);
  endfunction

  function automatic int ph_width(input int dw);
    return $clog2(frame_ticks(dw));
  endfunction
endpackage

// File: rtl/spi_tx_holdreg.sv
module spi_tx_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      full <= 1'b0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_valid && !full) begin
      full <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
    end else if (en && wr_valid && !full) begin
      data <= wr_data;
    end
  end
endmodule

// File: rtl/spi_tx_sequencer.sv
module spi_tx_sequencer #(
  parameter int DATA_W = 8,
  parameter int PH_W   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            tick,
  input  logic            full,
  input  logic            wait_rd,
  input  logic            rx_full,
  output logic            take,
  output logic            busy,
  output logic [PH_W-1:0] ph
);
  localparam int FRAME_T = spi_host_tx_pkg::frame_ticks(DATA_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_T - 1);

  assign take = en && tick && !busy && full && (!wait_rd || !rx_full);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy <= 1'b0;
      ph   <= '0;
    end else if (tick && busy) begin
      if (ph == PH_LAST) begin
        busy <= 1'b0;
        ph   <= '0;
      end else begin
        ph <= ph + 1'b1;
      end
    end else if (take) begin
      busy <= 1'b1;
      ph   <= '0;
    end
  end
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
  parameter int DATA_W = 8,
  parameter int PH_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              take,
  input  logic [DATA_W-1:0] load_data,
  input  logic              busy,
  input  logic [PH_W-1:0]   ph,
  output logic              msb
);
  localparam int LEAD_T = spi_host_tx_pkg::TICKS_PER_BIT * spi_host_tx_pkg::LEAD_BITS;
  // Shift on the tick that ends a high half, except after the last bit.
  localparam logic [PH_W-1:0] SH_LO = PH_W'(LEAD_T + 1);
  localparam logic [PH_W-1:0] SH_HI = PH_W'(LEAD_T + 2 * DATA_W - 3);

  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (take) begin
      shreg <= load_data;
    end else if (tick && busy && ph[0] && ph >= SH_LO && ph <= SH_HI) begin
      shreg <= {shreg[DATA_W-2:0], 1'b0};
    end
  end

  assign msb = shreg[DATA_W-1];
endmodule

// File: rtl/spi_host_tx.sv
module spi_host_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              half_tick,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hold_for_rx,
  input  logic              rx_full,
  input  logic              force_sel_on,
  input  logic              force_sel_off,
  output logic              sclk,
  output logic              mosi,
  output logic              sel_n,
  output logic              tx_ready,
  output logic              tx_empty
);
  localparam int PH_W   = spi_host_tx_pkg::ph_width(DATA_W);
  localparam int LEAD_T = spi_host_tx_pkg::TICKS_PER_BIT * spi_host_tx_pkg::LEAD_BITS;
  localparam int DATA_T = spi_host_tx_pkg::TICKS_PER_BIT * DATA_W;
  localparam int TRL_T  = spi_host_tx_pkg::TICKS_PER_BIT * spi_host_tx_pkg::TRAIL_BITS;
  localparam logic [PH_W-1:0] CLK_LO = PH_W'(LEAD_T);
  localparam logic [PH_W-1:0] CLK_HI = PH_W'(LEAD_T + DATA_T);
  localparam logic [PH_W-1:0] SEL_HI = PH_W'(LEAD_T + DATA_T + TRL_T);

  logic              full;
  logic [DATA_W-1:0] hold_q;
  logic              take;
  logic              busy;
  logic [PH_W-1:0]   ph;
  logic              msb;
  logic              forced;

  spi_tx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .en(tx_en), .wr_valid(wr_valid), .wr_data(wr_data),
    .take(take), .full(full), .data(hold_q)
  );

  spi_tx_sequencer #(.DATA_W(DATA_W), .PH_W(PH_W)) u_seq (
    .clk(clk), .rst(rst), .en(tx_en), .tick(half_tick), .full(full),
    .wait_rd(hold_for_rx), .rx_full(rx_full), .take(take), .busy(busy), .ph(ph)
  );

  spi_tx_shifter #(.DATA_W(DATA_W), .PH_W(PH_W)) u_shift (
    .clk(clk), .rst(rst), .tick(half_tick), .take(take), .load_data(hold_q),
    .busy(busy), .ph(ph), .msb(msb)
  );

  // Release wins over force when both arrive together.
  always_ff @(posedge clk) begin
    if (rst || force_sel_off) begin
      forced <= 1'b0;
    end else if (force_sel_on) begin
      forced <= 1'b1;
    end
  end

  assign sclk     = busy && ph[0] && ph >= CLK_LO && ph < CLK_HI;
  assign mosi     = busy && msb;
  assign sel_n    = !(forced || (busy && ph < SEL_HI));
  assign tx_ready = tx_en && !full;
  assign tx_empty = tx_en && !full && !busy;
endmodule

// File: rtl/spi_host_tx_checker.sv
module spi_host_tx_checker (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic half_tick,
  input logic hold_for_rx,
  input logic rx_full,
  input logic force_sel_on,
  input logic force_sel_off,
  input logic sclk,
  input logic mosi,
  input logic sel_n,
  input logic tx_ready,
  input logic tx_empty
);
  a_r7_flags_off: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> (!tx_ready && !tx_empty));

  a_r6_empty_means_ready: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> tx_ready);

  a_r2_clock_inside_select: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !sel_n);

  a_r11_sclk_paced: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk) |-> ($past(half_tick) || !$past(tx_en)));

  a_r11_mosi_paced: assert property (@(posedge clk) disable iff (rst)
    !$stable(mosi) |-> ($past(half_tick) || !$past(tx_en)));

  a_r9_hold_off: assert property (@(posedge clk) disable iff (rst)
    ($fell(sel_n) && $past(hold_for_rx) && !$past(force_sel_on)) |-> !$past(rx_full));

  a_r10_force_low: assert property (@(posedge clk) disable iff (rst)
    ($past(force_sel_on) && !$past(force_sel_off)) |-> !sel_n);
endmodule

bind spi_host_tx spi_host_tx_checker u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .half_tick(half_tick),
  .hold_for_rx(hold_for_rx), .rx_full(rx_full), .force_sel_on(force_sel_on),
  .force_sel_off(force_sel_off), .sclk(sclk), .mosi(mosi), .sel_n(sel_n),
  .tx_ready(tx_ready), .tx_empty(tx_empty)
);

// File: tb/spi_host_tx_bench.sv
`timescale 1ns/1ps
module spi_host_tx_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, half_tick = 1'b0, wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic hold_for_rx = 1'b0, rx_full = 1'b0, force_sel_on = 1'b0, force_sel_off = 1'b0;
  logic sclk, mosi, sel_n, tx_ready, tx_empty;

  always #2 clk = ~clk;

  spi_host_tx #(.DATA_W(8)) u_spi_host_tx (
    .clk(clk), .rst(rst), .tx_en(tx_en), .half_tick(half_tick),
    .wr_valid(wr_valid), .wr_data(wr_data), .hold_for_rx(hold_for_rx),
    .rx_full(rx_full), .force_sel_on(force_sel_on), .force_sel_off(force_sel_off),
    .sclk(sclk), .mosi(mosi), .sel_n(sel_n), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  int vectors = 0, errors = 0;
  bit tick_on = 1'b0;
  bit done = 1'b0;

  // Behavioural reference: a frame is 22 ticks, counted as an integer position.
  bit m_full = 0, m_busy = 0, m_forced = 0;
  int m_pos = 0;
  logic [7:0] m_hold = '0, m_char = '0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];

  always @(posedge clk) begin
    bit start;
    bit wr_ok;
    if (rst) begin
      m_full = 0; m_busy = 0; m_pos = 0; m_forced = 0;
    end else begin
      if (force_sel_off) m_forced = 0;
      else if (force_sel_on) m_forced = 1;
      if (!tx_en) begin
        m_full = 0; m_busy = 0; m_pos = 0;
      end else begin
        wr_ok = wr_valid && !m_full;
        start = half_tick && !m_busy && m_full && (!hold_for_rx || !rx_full);
        if (half_tick && m_busy) begin
          if (m_pos == 21) begin
            m_busy = 0; m_pos = 0; exp_q.push_back(m_char);
          end else m_pos++;
        end else if (start) begin
          m_busy = 1; m_pos = 0; m_char = m_hold; m_full = 0;
        end
        if (wr_ok) begin
          m_full = 1; m_hold = wr_data;
        end
      end
    end
  end

  task automatic cmp(input string req, input string name, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %0b expected %0b", req, name, $time, act, exp);
    end
  endtask

  logic prev_sclk = 1'b0;
  logic [7:0] cap = '0;
  int cap_bits = 0;

  always @(posedge clk) begin
    logic e_sel, e_clk, e_dat, e_rdy, e_emp;
    int b;
    #1;
    e_rdy = tx_en && !m_full;
    e_emp = e_rdy && !m_busy;
    e_sel = !(m_forced || (m_busy && m_pos < 20));
    e_clk = m_busy && m_pos >= 2 && m_pos < 18 && (m_pos % 2 == 1);
    if (!m_busy) e_dat = 1'b0;
    else if (m_pos < 2) e_dat = m_char[7];
    else if (m_pos >= 18) e_dat = m_char[0];
    else begin
      b = (m_pos - 2) / 2;
      e_dat = m_char[7 - b];
    end
    cmp("R3,R4,R10", "sel_n", sel_n, e_sel);
    cmp("R2", "sclk", sclk, e_clk);
    cmp("R2", "mosi", mosi, e_dat);
    cmp("R5", "tx_ready", tx_ready, e_rdy);
    cmp("R6", "tx_empty", tx_empty, e_emp);
    if (sel_n) cap_bits = 0;
    else if (sclk && !prev_sclk) begin
      cap = {cap[6:0], mosi};
      cap_bits++;
      if (cap_bits == 8) begin
        got_q.push_back(cap);
        cap_bits = 0;
      end
    end
    prev_sclk = sclk;
  end

  // Tick source: one pulse every third cycle while enabled.
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      n++;
      half_tick = tick_on && (n % 3 == 0);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_flag(input bit want_empty);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (want_empty ? tx_empty : tx_ready) return;
    end
  endtask

  task automatic pt(input string req, input string name, input logic act, input logic exp);
    cmp(req, name, act, exp);
  endtask

  initial begin
    cycles(4);
    pt("R1", "sel_n in reset", sel_n, 1'b1);
    pt("R1", "sclk in reset", sclk, 1'b0);
    rst = 1'b0;
    cycles(2);
    pt("R1", "tx_ready disabled", tx_ready, 1'b0);
    pt("R1", "tx_empty disabled", tx_empty, 1'b0);

    tx_en = 1'b1;
    cycles(1);
    pt("R7", "tx_ready on enable", tx_ready, 1'b1);
    pt("R7", "tx_empty on enable", tx_empty, 1'b1);

    // R8: second write lands while the holding register is still full.
    write(8'hA5);
    pt("R5", "tx_ready after write", tx_ready, 1'b0);
    write(8'hFF);
    tick_on = 1'b1;
    wait_flag(0);
    write(8'h3C);
    wait_flag(1);

    // R9: hold-off while the receive side is full.
    hold_for_rx = 1'b1; rx_full = 1'b1;
    write(8'h81);
    cycles(90);
    pt("R9", "sel_n during hold-off", sel_n, 1'b1);
    pt("R9", "tx_ready during hold-off", tx_ready, 1'b0);
    rx_full = 1'b0;
    wait_flag(1);
    hold_for_rx = 1'b0;
    rx_full = 1'b1;  // no effect with hold-off disabled

    // R10: forced select across two characters.
    @(negedge clk); force_sel_on = 1'b1;
    @(negedge clk); force_sel_on = 1'b0;
    write(8'h5A);
    wait_flag(0);
    write(8'hC3);
    wait_flag(1);
    cycles(10);
    pt("R10", "sel_n held between characters", sel_n, 1'b0);
    @(negedge clk); force_sel_on = 1'b1; force_sel_off = 1'b1;
    @(negedge clk); force_sel_on = 1'b0; force_sel_off = 1'b0;
    pt("R10", "sel_n after release", sel_n, 1'b1);
    rx_full = 1'b0;

    // R7: disable mid-frame, then write while disabled.
    write(8'h96);
    cycles(25);
    tx_en = 1'b0;
    cycles(1);
    pt("R7", "sel_n after disable", sel_n, 1'b1);
    pt("R7", "tx_ready after disable", tx_ready, 1'b0);
    write(8'h11);
    tx_en = 1'b1;
    cycles(80);
    pt("R7", "tx_empty after re-enable", tx_empty, 1'b1);
    pt("R7", "no frame from disabled write", sel_n, 1'b1);

    // R2, R8: serial bytes match completed characters (A5,3C,81,5A,C3).
    vectors++;
    if (got_q.size() != 5 || exp_q.size() != 5) begin
      errors++;
      $display("FAIL R2 R8 byte count: actual %0d expected %0d (model %0d)",
               got_q.size(), 5, exp_q.size());
    end else begin
      for (int i = 0; i < 5; i++) begin
        vectors++;
        if (got_q[i] !== exp_q[i]) begin
          errors++;
          $display("FAIL R2 byte %0d: actual %02h expected %02h", i, got_q[i], exp_q[i]);
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule